// File: doc/BRIEF.md
# Four-Phase Interlocked Read Link

This block joins a requesting agent and a word-serving agent over one shared set of data lines and three control lines: a request strobe, an acknowledge line and a data-ready strobe. A read moves through seven steps. The requester puts an address on the data lines and raises the request. The server takes the address and acknowledges. The requester then lets go of the lines and drops the request. The server drops its acknowledge, drives the word and raises data-ready. The requester captures the word and acknowledges. The server drops data-ready and releases the lines. Last, the requester drops its acknowledge. Each step waits for a change on a control line driven by the other side, so neither agent relies on how fast the other one is.

Both agents share one clock. Each agent has a hold input that freezes its handshake state for as long as the input is high. This lets an arbitrary number of idle cycles appear between any two steps. The server's words come from a small read-only array whose contents are computed from its index. Local user logic issues a read with a start pulse and an address. It receives a one-cycle done pulse and the returned word. The drive enables of both agents are visible at the ports, and a simple multiplexer stands in for the tristate bus.

Top module: `hs_read_link`

## Requirements
- R1: While rst_n is low, and in the first cycle after its release, the outputs line_req, line_ack, line_rdy, req_drive_en, rsp_drive_en, rd_busy and rd_done are all low.
- R2: A start pulse seen while the requester is idle raises line_req in the next cycle. From that cycle the requester drives the address, zero-extended, on line_data, and it holds that value unchanged while line_req stays high.
- R3: The server answers line_req by raising line_ack and capturing the low address bits from line_data. The requester answers that acknowledge by dropping line_req and its drive enable. line_req never falls while line_ack is low.
- R4: req_drive_en and rsp_drive_en are never high in the same cycle. When neither is high, line_data reads zero.
- R5: When the server sees line_req low while it acknowledges, it drops line_ack, enables its drive and raises line_rdy, all in the same cycle. line_rdy never rises while line_req or line_ack is high.
- R6: The word returned for address a is the low DW bits of (PAT_SEED xor a*PAT_STEP). With the defaults (DW 8, PAT_SEED 0x5A, PAT_STEP 0x1D), address 5 returns 0xCB. line_data stays stable while line_rdy stays high.
- R7: The requester answers line_rdy by capturing line_data and raising line_ack. The server answers that by dropping line_rdy and its drive enable. line_rdy never falls while line_ack is low.
- R8: The requester ends the transfer by dropping line_ack after it sees line_rdy low. A new line_req rises only while line_ack and line_rdy are both low.
- R9: rd_done is a one-cycle pulse raised as the requester returns to idle. In that cycle rd_data holds the captured word, and it keeps that word until the next capture. With both hold inputs low, rd_done is high exactly seven cycles after the cycle in which start is accepted.
- R10: rd_busy is high from the cycle after start is accepted until rd_done. A start pulse that arrives while rd_busy is high is ignored: it changes neither the address in flight nor the returned word, and it starts no extra transfer.
- R11: While req_hold or rsp_hold is high, the matching agent keeps its handshake state. Under random holds on either side or on both, every transfer completes and returns the correct word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | User pulse that requests a read |
| rd_addr | input | AW | Address for the read, sampled with start |
| req_hold | input | 1 | Freezes the requester's handshake steps |
| rsp_hold | input | 1 | Freezes the server's handshake steps |
| rd_busy | output | 1 | Requester is inside a transfer |
| rd_done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | DW | Last word captured by the requester |
| line_req | output | 1 | Read request control line |
| line_ack | output | 1 | Acknowledge line, OR of both agents |
| line_rdy | output | 1 | Data-ready control line |
| line_data | output | DW | Resolved shared data lines |
| req_drive_en | output | 1 | Requester drives the data lines |
| rsp_drive_en | output | 1 | Server drives the data lines |

## Verification
The properties run on every cycle. They check the interlock on the control lines: each edge of the request and data-ready strobes may only happen at the right level of the other lines. They also check that the drive enables never overlap, that the data lines stay stable while either strobe is high, and that done lasts a single cycle. The bench scenarios are the only way to show the rest: that the captured word matches the address sent, the exact seven-cycle latency, the step-by-step trace of the seven phases, that a start during a transfer is discarded, and that random holds on either side still let every transfer finish correctly.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    RQ_IDLE = 2'd0,
    RQ_ADDR = 2'd1,
    RQ_WAIT = 2'd2,
    RQ_ACK  = 2'd3
  } rq_state_e;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_ACKED = 2'd1,
    RS_DATA  = 2'd2
  } rs_state_e;

endpackage

// File: rtl/hs_word_store.sv
module hs_word_store #(
  parameter int          AW       = 4,
  parameter int          DW       = 8,
  parameter int unsigned PAT_SEED = 32'h5A,
  parameter int unsigned PAT_STEP = 32'h1D
) (
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);

  localparam int DEPTH = 1 << AW;

  function automatic logic [DW-1:0] pattern(input int unsigned idx);
    logic [31:0] p;
    p = PAT_SEED ^ (idx * PAT_STEP);
    return p[DW-1:0];
  endfunction

  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign words[g] = pattern(g);
  end

  assign rd_word = words[rd_addr];

endmodule

// File: rtl/hs_requester.sv
module hs_requester
  import hs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          hold_i,
  input  logic          ack_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] bus_i,
  output logic          req_o,
  output logic          ack_o,
  output logic          oe_o,
  output logic [DW-1:0] drv_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);

  rq_state_e     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata_q;
  logic          done_q, done_d;
  logic          addr_en, data_en;
  logic          step;

  assign step = !hold_i;

  always_comb begin
    state_d = state_q;
    addr_en = 1'b0;
    data_en = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      RQ_IDLE: if (start_i) begin
        state_d = RQ_ADDR;
        addr_en = 1'b1;
      end
      RQ_ADDR: if (ack_i && step) state_d = RQ_WAIT;
      RQ_WAIT: if (rdy_i && step) begin
        state_d = RQ_ACK;
        data_en = 1'b1;
      end
      RQ_ACK: if (!rdy_i && step) begin
        state_d = RQ_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (data_en) begin
      rdata_q <= bus_i;
    end
  end

  assign req_o   = (state_q == RQ_ADDR);
  assign oe_o    = (state_q == RQ_ADDR);
  assign ack_o   = (state_q == RQ_ACK);
  assign busy_o  = (state_q != RQ_IDLE);
  assign drv_o   = DW'(addr_q);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          req_i,
  input  logic          ack_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] word_i,
  output logic          ack_o,
  output logic          rdy_o,
  output logic          oe_o,
  output logic [DW-1:0] drv_o,
  output logic [AW-1:0] word_addr_o
);

  rs_state_e     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          addr_en;
  logic          step;

  assign step = !hold_i;

  always_comb begin
    state_d = state_q;
    addr_en = 1'b0;
    case (state_q)
      RS_IDLE: if (req_i && step) begin
        state_d = RS_ACKED;
        addr_en = 1'b1;
      end
      RS_ACKED: if (!req_i && step) state_d = RS_DATA;
      RS_DATA:  if (ack_i && step)  state_d = RS_IDLE;
      default:  state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= bus_addr_i;
    end
  end

  assign ack_o       = (state_q == RS_ACKED);
  assign rdy_o       = (state_q == RS_DATA);
  assign oe_o        = (state_q == RS_DATA);
  assign drv_o       = word_i;
  assign word_addr_o = addr_q;

endmodule

// File: rtl/hs_read_link.sv
module hs_read_link #(
  parameter int          AW       = 4,
  parameter int          DW       = 8,
  parameter int unsigned PAT_SEED = 32'h5A,
  parameter int unsigned PAT_STEP = 32'h1D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] rd_addr,
  input  logic          req_hold,
  input  logic          rsp_hold,
  output logic          rd_busy,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          line_req,
  output logic          line_ack,
  output logic          line_rdy,
  output logic [DW-1:0] line_data,
  output logic          req_drive_en,
  output logic          rsp_drive_en
);

  logic          rq_ack, rs_ack;
  logic [DW-1:0] rq_drv, rs_drv;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] word;

  hs_requester #(.AW(AW), .DW(DW)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .addr_i  (rd_addr),
    .hold_i  (req_hold),
    .ack_i   (line_ack),
    .rdy_i   (line_rdy),
    .bus_i   (line_data),
    .req_o   (line_req),
    .ack_o   (rq_ack),
    .oe_o    (req_drive_en),
    .drv_o   (rq_drv),
    .busy_o  (rd_busy),
    .done_o  (rd_done),
    .rdata_o (rd_data)
  );

  hs_responder #(.AW(AW), .DW(DW)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (rsp_hold),
    .req_i       (line_req),
    .ack_i       (line_ack),
    .bus_addr_i  (line_data[AW-1:0]),
    .word_i      (word),
    .ack_o       (rs_ack),
    .rdy_o       (line_rdy),
    .oe_o        (rsp_drive_en),
    .drv_o       (rs_drv),
    .word_addr_o (word_addr)
  );

  hs_word_store #(
    .AW(AW), .DW(DW), .PAT_SEED(PAT_SEED), .PAT_STEP(PAT_STEP)
  ) u_store (
    .rd_addr (word_addr),
    .rd_word (word)
  );

  // Acknowledge is a shared line: either agent may pull it high.
  assign line_ack = rq_ack | rs_ack;

  // Tristate model: the enabled driver wins, released lines read zero.
  always_comb begin
    if (req_drive_en)      line_data = rq_drv;
    else if (rsp_drive_en) line_data = rs_drv;
    else                   line_data = '0;
  end

endmodule

// File: rtl/hs_read_link_chk.sv
module hs_read_link_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_req,
  input logic          line_ack,
  input logic          line_rdy,
  input logic [DW-1:0] line_data,
  input logic          req_drive_en,
  input logic          rsp_drive_en,
  input logic          rd_done
);

  assert_no_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_drive_en && rsp_drive_en));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req && $past(line_req)) |-> $stable(line_data));

  assert_req_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_req) |-> line_ack);

  assert_rdy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_rdy) |-> (!line_req && !line_ack));

  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rdy && $past(line_rdy)) |-> $stable(line_data));

  assert_rdy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_rdy) |-> line_ack);

  assert_new_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_req) |-> (!line_ack && !line_rdy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (!line_ack && !line_rdy && !line_req));

endmodule

bind hs_read_link hs_read_link_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_req     (line_req),
  .line_ack     (line_ack),
  .line_rdy     (line_rdy),
  .line_data    (line_data),
  .req_drive_en (req_drive_en),
  .rsp_drive_en (rsp_drive_en),
  .rd_done      (rd_done)
);

// File: tb/sim_hs_read_link.sv
module sim_hs_read_link;

  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] rd_addr;
  logic          req_hold;
  logic          rsp_hold;
  logic          rd_busy;
  logic          rd_done;
  logic [DW-1:0] rd_data;
  logic          line_req;
  logic          line_ack;
  logic          line_rdy;
  logic [DW-1:0] line_data;
  logic          req_drive_en;
  logic          rsp_drive_en;

  int checks = 0;
  int errors = 0;
  logic [1:0] hold_mode = 2'd0;
  bit finished = 1'b0;

  hs_read_link u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
    .req_hold(req_hold), .rsp_hold(rsp_hold),
    .rd_busy(rd_busy), .rd_done(rd_done), .rd_data(rd_data),
    .line_req(line_req), .line_ack(line_ack), .line_rdy(line_rdy),
    .line_data(line_data), .req_drive_en(req_drive_en),
    .rsp_drive_en(rsp_drive_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Random holds, bit 0 of the mode for the requester, bit 1 for the server.
  always @(negedge clk) begin
    req_hold = hold_mode[0] ? ($urandom_range(0, 2) == 0) : 1'b0;
    rsp_hold = hold_mode[1] ? ($urandom_range(0, 2) == 0) : 1'b0;
  end

  // {hold mode, address, expected word}
  localparam logic [13:0] VEC [8] = '{
    {2'd0, 4'd1,  8'h47},
    {2'd1, 4'd5,  8'hCB},
    {2'd2, 4'd7,  8'h91},
    {2'd3, 4'd9,  8'h5F},
    {2'd3, 4'd10, 8'h78},
    {2'd1, 4'd15, 8'hE9},
    {2'd2, 4'd3,  8'h0D},
    {2'd0, 4'd0,  8'h5A}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic quiet_check(input string tag);
    check({line_req, line_ack, line_rdy, req_drive_en, rsp_drive_en, rd_busy, rd_done} == 7'b0,
          tag, {line_req, line_ack, line_rdy, req_drive_en, rsp_drive_en, rd_busy, rd_done}, 0);
  endtask

  // Issue a start (called just after a clock edge) and return the cycles to done.
  task automatic run_xfer(input logic [AW-1:0] a, output int lat);
    start   = 1'b1;
    rd_addr = a;
    lat = 0;
    for (int n = 1; n <= 3000; n++) begin
      @(posedge clk); #1;
      start = 1'b0;
      if (rd_done) begin
        lat = n;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    rst_n = 1'b0;
    start = 1'b0;
    rd_addr = '0;
    req_hold = 1'b0;
    rsp_hold = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    quiet_check("R1 outputs in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    quiet_check("R1 outputs after release");

    // Step-by-step trace of one transfer, no holds, address 5.
    start = 1'b1; rd_addr = 4'd5;
    @(posedge clk); #1; start = 1'b0;
    check(line_req && req_drive_en && !line_ack, "R2 request raised", {line_req, req_drive_en, line_ack}, 3'b110);
    check(line_data == 8'h05, "R2 address on lines", line_data, 8'h05);
    check(rd_busy, "R10 busy after start", rd_busy, 1);
    @(posedge clk); #1;
    check(line_req && line_ack, "R3 server acknowledges", {line_req, line_ack}, 2'b11);
    @(posedge clk); #1;
    check(!line_req && line_ack && !req_drive_en && !rsp_drive_en, "R3 request dropped, lines released",
          {line_req, line_ack, req_drive_en, rsp_drive_en}, 4'b0100);
    check(line_data == 8'h00, "R4 released lines read zero", line_data, 0);
    @(posedge clk); #1;
    check(!line_ack && line_rdy && rsp_drive_en, "R5 data ready raised", {line_ack, line_rdy, rsp_drive_en}, 3'b011);
    check(line_data == 8'hCB, "R6 word for address 5", line_data, 8'hCB);
    @(posedge clk); #1;
    check(line_ack && line_rdy, "R7 requester acknowledges", {line_ack, line_rdy}, 2'b11);
    check(rd_data == 8'hCB, "R7 word captured", rd_data, 8'hCB);
    @(posedge clk); #1;
    check(line_ack && !line_rdy && !rsp_drive_en, "R7 data ready dropped", {line_ack, line_rdy, rsp_drive_en}, 3'b100);
    @(posedge clk); #1;
    check(!line_ack && rd_done && !rd_busy, "R8 transfer ends with done", {line_ack, rd_done, rd_busy}, 3'b010);
    @(posedge clk); #1;
    check(!rd_done && rd_data == 8'hCB, "R9 done one cycle, word held", {rd_done, rd_data}, {1'b0, 8'hCB});

    // Table of transfers under several hold patterns.
    for (int rep = 0; rep < 4; rep++) begin
      for (int i = 0; i < 8; i++) begin
        hold_mode = VEC[i][13:12];
        run_xfer(VEC[i][11:8], lat);
        check(lat != 0, "R11 transfer completes", lat, 1);
        check(rd_data == VEC[i][7:0], "R6/R11 returned word", rd_data, VEC[i][7:0]);
        if (VEC[i][13:12] == 2'd0)
          check(lat == 7, "R9 latency without holds", lat, 7);
        hold_mode = 2'd0;
        @(posedge clk); #1;
      end
    end

    // Start while busy is ignored.
    hold_mode = 2'd0;
    @(posedge clk); #1;
    start = 1'b1; rd_addr = 4'd5;
    @(posedge clk); #1;
    rd_addr = 4'd9;
    @(posedge clk); #1;
    check(line_data == 8'h05, "R10 address in flight kept", line_data, 8'h05);
    @(posedge clk); #1;
    start = 1'b0;
    begin
      int dn = 0;
      logic [DW-1:0] got = '0;
      for (int n = 0; n < 30; n++) begin
        if (rd_done) begin
          dn++;
          got = rd_data;
        end
        @(posedge clk); #1;
      end
      check(dn == 1, "R10 single done for ignored start", dn, 1);
      check(got == 8'hCB, "R10 word of first address", got, 8'hCB);
      check(!line_req && !rd_busy, "R10 no extra transfer", {line_req, rd_busy}, 0);
    end

    // Reset in the middle of a transfer.
    start = 1'b1; rd_addr = 4'd7;
    @(posedge clk); #1; start = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    quiet_check("R1 async reset mid transfer");
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    quiet_check("R1 idle after mid-transfer reset");
    run_xfer(4'd15, lat);
    check(lat == 7 && rd_data == 8'hE9, "R9 clean transfer after reset", {lat[7:0], rd_data}, {8'd7, 8'hE9});

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule